// File: doc/BRIEF.md
# Cycle-Steal DMA Bus Request Throttler

This block sits between a DMA channel's transfer sequencer and the system bus arbiter. It paces how often the DMA engine takes the bus in cycle-steal operation. A level-sensitive, active-low external transfer request wakes it. It then raises a bus request and holds it until the arbiter grants. It lets exactly one transfer unit of data beats through during that tenure and then gives the bus back with a single-cycle release pulse.

A 2-bit cycle-mode select chooses between plain cycle stealing and two intermittent variants. In plain cycle stealing, a new request may follow the release at once. The intermittent variants hold off the next request for 16 or 64 bus clocks, which lowers the share of bus time the DMA occupies. Intermittent pacing is only legal when every channel runs in cycle-steal bus mode. If that is not the case, the block flags a configuration error and paces as plain cycle stealing.

A 16-bit remaining-unit counter is loaded from outside and decremented once per completed unit. When it reaches zero the block reports done and stops requesting until it is reloaded.

Top module: `dma_cs_throttle`

## Requirements
- R1: After reset, bus_req and bus_rel are low, remaining is 0 and done is high.
- R2: With cyc_mode 00 or 01 and a request pending, bus_req rises in the cycle right after the bus_rel cycle.
- R3: With all_chan_steal high, cyc_mode 10 leaves exactly 16 cycles with bus_req low between the bus_rel cycle and the next bus_req, and cyc_mode 11 leaves exactly 64.
- R4: cyc_mode 10 or 11 with all_chan_steal low drives cfg_err high, and pacing then follows R2 (no gap). With all_chan_steal high, or with cyc_mode 00 or 01, cfg_err is low.
- R5: Once raised, bus_req stays high until bus_gnt is sampled high, and it is low in the following cycle.
- R6: One tenure carries exactly one unit. unit_code selects 0:1 byte, 1:2 bytes, 2:4 bytes, 3:16 bytes, 4:32 bytes, and 5 to 7 act as 1 byte. The unit needs max(1, bytes/BUS_BYTES) beat_ack pulses; with BUS_BYTES=4 that is 1,1,1,4,8.
- R7: bus_rel is a one-cycle pulse in the cycle right after the cycle in which the final beat_ack of the unit is sampled.
- R8: remaining drops by one in the bus_rel cycle. done is high exactly when remaining is 0. No bus_req is raised while done is high.
- R9: A request is xfer_req_n low. A low level lasting a single cycle during the gap, or while still done, is held pending and served later. With xfer_req_n held high, no bus_req is raised.
- R10: A load pulse sets remaining to load_count in the next cycle. Loading 0 sets done, and loading a non-zero value clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_req_n | input | 1 | External transfer request, active low, level sensed |
| cyc_mode | input | 2 | Cycle mode: 00/01 plain, 10 gap 16, 11 gap 64 |
| all_chan_steal | input | 1 | High when every channel is in cycle-steal bus mode |
| unit_code | input | 3 | Transfer unit size code |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| beat_ack | input | 1 | One data beat of the unit acknowledged |
| bus_rel | output | 1 | One-cycle bus release pulse |
| load | input | 1 | Load pulse for the remaining-unit counter |
| load_count | input | CNT_W | Value loaded into the counter |
| remaining | output | CNT_W | Units still to transfer |
| done | output | 1 | Transfer end reached |
| cfg_err | output | 1 | Intermittent mode selected while not all channels steal cycles |

## Verification
The bench builds the block with its defaults: BUS_BYTES=4, a 16-bit counter and gaps of 16 and 64. This makes the 4- and 8-beat units of the 16- and 32-byte codes reachable, along with the full 64-cycle gap, within a short run. Random grant latency and random beat spacing cover the request-hold and release timing. Unit counts of one to six cover several gaps per run and the stop at zero. A pulsed-request style checks that a one-cycle request inside a gap is served exactly when the gap ends.

// File: rtl/dma_thr_pkg.sv
package dma_thr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_REL
    } thr_state_e;

    function automatic int unsigned unit_bytes(input logic [2:0] code);
        case (code)
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 16;
            3'd4:    return 32;
            default: return 1;
        endcase
    endfunction

    function automatic int unsigned unit_beats(input logic [2:0] code,
                                               input int unsigned bus_bytes);
        int unsigned b;
        b = unit_bytes(code) / bus_bytes;
        return (b == 0) ? 1 : b;
    endfunction

endpackage

// File: rtl/thr_mode_decode.sv
module thr_mode_decode #(
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64,
    parameter int GAP_W     = $clog2(GAP_LONG + 1)
) (
    input  logic [1:0]       cyc_mode,
    input  logic             all_chan_steal,
    output logic [GAP_W-1:0] gap_len,
    output logic             cfg_err
);
    logic intermittent;

    always_comb begin
        intermittent = cyc_mode[1];
        cfg_err      = intermittent && !all_chan_steal;
        gap_len      = '0;
        if (intermittent && all_chan_steal) begin
            gap_len = cyc_mode[0] ? GAP_W'(GAP_LONG) : GAP_W'(GAP_SHORT);
        end
    end
endmodule

// File: rtl/thr_gap_timer.sv
module thr_gap_timer #(
    parameter int GAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] len,
    output logic             busy
);
    typedef struct packed {
        logic [GAP_W-1:0] gap;
    } gap_regs_t;

    gap_regs_t gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (start) begin
            gap_d.gap = len;
        end else if (gap_q.gap != '0) begin
            gap_d.gap = gap_q.gap - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign busy = (gap_q.gap != '0);

    assert_gap_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q.gap != '0 && !start) |=> (gap_q.gap == $past(gap_q.gap) - 1'b1));
endmodule

// File: rtl/thr_unit_ctr.sv
module thr_unit_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] remaining,
    output logic             done
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctr_regs_t;

    ctr_regs_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.cnt  = load_val;
            ctr_d.done = (load_val == '0);
        end else if (dec && ctr_q.cnt != '0) begin
            ctr_d.cnt  = ctr_q.cnt - 1'b1;
            ctr_d.done = (ctr_q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.cnt  <= '0;
            ctr_q.done <= 1'b1;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign remaining = ctr_q.cnt;
    assign done      = ctr_q.done;

    assert_dec_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && ctr_q.cnt != '0) |=> (ctr_q.cnt == $past(ctr_q.cnt) - 1'b1));
    assert_done_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.cnt == '0) == ctr_q.done);
    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ctr_q.cnt == $past(load_val)));
endmodule

// File: rtl/dma_cs_throttle.sv
module dma_cs_throttle
    import dma_thr_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int CNT_W     = 16,
    parameter int GAP_SHORT = 16,
    parameter int GAP_LONG  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_req_n,
    input  logic [1:0]       cyc_mode,
    input  logic             all_chan_steal,
    input  logic [2:0]       unit_code,
    output logic             bus_req,
    input  logic             bus_gnt,
    input  logic             beat_ack,
    output logic             bus_rel,
    input  logic             load,
    input  logic [CNT_W-1:0] load_count,
    output logic [CNT_W-1:0] remaining,
    output logic             done,
    output logic             cfg_err
);
    localparam int GAP_W    = $clog2(GAP_LONG + 1);
    localparam int MAX_BEAT = (32 / BUS_BYTES < 1) ? 1 : 32 / BUS_BYTES;
    localparam int BEAT_W   = $clog2(MAX_BEAT + 1);

    typedef struct packed {
        thr_state_e        state;
        logic              pend;
        logic [BEAT_W-1:0] beats_tgt;
        logic [BEAT_W-1:0] beat_cnt;
    } fsm_regs_t;

    fsm_regs_t fsm_d, fsm_q;

    logic [GAP_W-1:0] gap_len;
    logic             gap_busy;
    logic             unit_end;
    logic             pend_in;

    thr_mode_decode #(
        .GAP_SHORT(GAP_SHORT),
        .GAP_LONG (GAP_LONG),
        .GAP_W    (GAP_W)
    ) u_mode (
        .cyc_mode      (cyc_mode),
        .all_chan_steal(all_chan_steal),
        .gap_len       (gap_len),
        .cfg_err       (cfg_err)
    );

    thr_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .start(unit_end),
        .len  (gap_len),
        .busy (gap_busy)
    );

    thr_unit_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_count),
        .dec      (unit_end),
        .remaining(remaining),
        .done     (done)
    );

    always_comb begin
        fsm_d    = fsm_q;
        unit_end = 1'b0;
        pend_in  = fsm_q.pend || !xfer_req_n;
        fsm_d.pend = pend_in;
        case (fsm_q.state)
            ST_IDLE, ST_REL: begin
                fsm_d.state = ST_IDLE;
                if (pend_in && !done && !gap_busy) begin
                    fsm_d.state     = ST_REQ;
                    fsm_d.pend      = 1'b0;
                    fsm_d.beats_tgt = BEAT_W'(unit_beats(unit_code, BUS_BYTES));
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    fsm_d.state    = ST_XFER;
                    fsm_d.beat_cnt = '0;
                end
            end
            ST_XFER: begin
                if (beat_ack) begin
                    if (fsm_q.beat_cnt == fsm_q.beats_tgt - 1'b1) begin
                        fsm_d.state = ST_REL;
                        unit_end    = 1'b1;
                    end else begin
                        fsm_d.beat_cnt = fsm_q.beat_cnt + 1'b1;
                    end
                end
            end
            default: fsm_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state     <= ST_IDLE;
            fsm_q.pend      <= 1'b0;
            fsm_q.beats_tgt <= '0;
            fsm_q.beat_cnt  <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign bus_req = (fsm_q.state == ST_REQ);
    assign bus_rel = (fsm_q.state == ST_REL);

    assert_cfg_nogap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_end && cfg_err) |=> !gap_busy);
    assert_gap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_busy && !bus_req) |=> !bus_req);
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt) |=> bus_req);
    assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> !bus_req);
    assert_rel_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rel |=> !bus_rel);
    assert_rel_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rel) |-> $past(beat_ack));
    assert_no_req_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !bus_req) |=> !bus_req);
endmodule

// File: tb/dma_cs_throttle_test.sv
`timescale 1ns/1ps
module dma_cs_throttle_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_req_n = 1'b1;
    logic [1:0]  cyc_mode = 2'b00;
    logic        all_chan_steal = 1'b1;
    logic [2:0]  unit_code = 3'd0;
    logic        bus_req;
    logic        bus_gnt = 1'b0;
    logic        beat_ack = 1'b0;
    logic        bus_rel;
    logic        load = 1'b0;
    logic [15:0] load_count = '0;
    logic [15:0] remaining;
    logic        done;
    logic        cfg_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dma_cs_throttle uut (
        .clk(clk), .rst_n(rst_n), .xfer_req_n(xfer_req_n), .cyc_mode(cyc_mode),
        .all_chan_steal(all_chan_steal), .unit_code(unit_code), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .beat_ack(beat_ack), .bus_rel(bus_rel), .load(load),
        .load_count(load_count), .remaining(remaining), .done(done), .cfg_err(cfg_err)
    );

    function automatic int exp_beats(input logic [2:0] code);
        int b;
        case (code)
            3'd1: b = 2; 3'd2: b = 4; 3'd3: b = 16; 3'd4: b = 32;
            default: b = 1;
        endcase
        return (b / 4 < 1) ? 1 : b / 4;
    endfunction

    function automatic int exp_gap(input logic [1:0] m, input logic all_cs);
        if (m[1] && all_cs) return m[0] ? 64 : 16;
        return 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // style 0: request held low; style 1: one-cycle pulses (with load and 3 cycles after each release)
    task automatic run_case(input logic [1:0] m, input logic all_cs, input logic [2:0] uc,
                            input int count, input int style, input int max_gnt_wait);
        int c, units, acks, last_ack, exp_req, pulse_at, gnt_wait, g, nb;
        bit gnt_given, prev_req, prev_rel;
        g  = exp_gap(m, all_cs);
        nb = exp_beats(uc);
        cyc_mode = m; all_chan_steal = all_cs; unit_code = uc;
        @(negedge clk);
        // R4: error flag from mode and channel configuration
        check(cfg_err == (m[1] && !all_cs), "R4 cfg_err", cfg_err, (m[1] && !all_cs));
        load = 1'b1; load_count = 16'(count); xfer_req_n = 1'b0;
        c = 0; units = 0; acks = 0; last_ack = -10; exp_req = 2; pulse_at = -1;
        gnt_given = 0; prev_req = 0; prev_rel = 0; gnt_wait = 0;
        while (units < count && c < 2000) begin
            @(negedge clk);
            c++;
            load = 1'b0;
            bus_gnt = 1'b0;
            beat_ack = 1'b0;
            if (c == 1) begin
                // R10: counter loaded
                check(remaining == 16'(count), "R10 remaining after load", remaining, count);
                check(done == 1'b0, "R10 done cleared by load", done, 0);
            end
            if (bus_rel) begin
                check(!prev_rel, "R7 release is one cycle", 1, 0);
                check(acks == nb, "R6 beats per unit", acks, nb);
                check(last_ack == c - 1, "R7 release after last ack", c - 1 - last_ack, 0);
                units++;
                check(remaining == 16'(count - units), "R8 remaining decrement", remaining, count - units);
                exp_req = (style == 1 && c + 4 > c + 1 + g) ? c + 4 : c + 1 + g;
                if (style == 1) pulse_at = c + 3;
                gnt_given = 0; acks = 0;
            end
            if (bus_req && !prev_req) begin
                if (g == 64 || g == 16)
                    check(c == exp_req, "R3 gap before request", c, exp_req);
                else if (m[1])
                    check(c == exp_req, "R4 no gap on config error", c, exp_req);
                else
                    check(c == exp_req, "R2 request after release", c, exp_req);
                gnt_wait = $urandom_range(max_gnt_wait, 0);
            end
            if (prev_req && !bus_req && !gnt_given)
                check(0, "R5 request dropped without grant", 0, 1);
            if (bus_req) begin
                if (gnt_given) check(0, "R5 request after grant", 1, 0);
                else if (gnt_wait == 0) begin bus_gnt = 1'b1; gnt_given = 1; end
                else gnt_wait--;
            end else if (gnt_given && acks < nb && $urandom_range(1, 0) == 1) begin
                beat_ack = 1'b1; acks++; last_ack = c;
            end
            if (style == 1) xfer_req_n = !(c == pulse_at);
            prev_req = bus_req; prev_rel = bus_rel;
        end
        check(units == count, "R8 all units transferred", units, count);
        xfer_req_n = 1'b0;
        // R8: done stops further requests even with request held low
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (bus_req) check(0, "R8 request while done", 1, 0);
        end
        check(done == 1'b1, "R8 done at zero", done, 1);
        check(remaining == 16'd0, "R8 remaining zero", remaining, 0);
        xfer_req_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd24681);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(bus_req == 1'b0, "R1 bus_req reset", bus_req, 0);
        check(bus_rel == 1'b0, "R1 bus_rel reset", bus_rel, 0);
        check(remaining == 16'd0, "R1 remaining reset", remaining, 0);
        check(done == 1'b1, "R1 done reset", done, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9: no request with xfer_req_n high
        load = 1'b1; load_count = 16'd2;
        @(negedge clk);
        load = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (bus_req) check(0, "R9 request without xfer_req_n", 1, 0);
        end
        check(remaining == 16'd2, "R9 no transfer without request", remaining, 2);
        // R10: load of zero gives done
        load = 1'b1; load_count = 16'd0;
        @(negedge clk);
        load = 1'b0;
        check(done == 1'b1, "R10 load zero sets done", done, 1);

        // directed corner cases
        run_case(2'b00, 1'b1, 3'd2, 3, 0, 0);   // R2 plain, back-to-back
        run_case(2'b01, 1'b1, 3'd0, 2, 0, 3);   // R2 code 01
        run_case(2'b10, 1'b1, 3'd3, 3, 0, 2);   // R3 gap 16, 4 beats
        run_case(2'b11, 1'b1, 3'd4, 2, 0, 1);   // R3 gap 64, 8 beats
        run_case(2'b11, 1'b0, 3'd1, 3, 0, 0);   // R4 config error
        run_case(2'b10, 1'b1, 3'd3, 3, 1, 2);   // R9 pulse held in gap
        run_case(2'b00, 1'b1, 3'd6, 2, 1, 1);   // R6 reserved code, R9 pulse
        // constrained random
        for (int i = 0; i < 10; i++) begin
            run_case(2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)),
                     3'($urandom_range(7, 0)), $urandom_range(6, 1),
                     $urandom_range(1, 0), $urandom_range(4, 0));
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule